// File: doc/BRIEF.md
# External Data-Memory Mode Controller

This block sits between a microcontroller core and everything that answers to its external-data-space instructions. For each access it forms an effective address and decides whether it lands in the 4 KB on-chip RAM or goes out to a 64 KB off-chip bus. In the 8-bit register-indirect form, the upper address byte comes from a page register, not from the core. Four memory-map modes set that decision: everything on-chip, everything off-chip, or one of two split maps that divide at the 4 KB line. The two split maps differ only in where the off-chip upper address byte comes from.

On-chip hits are presented to the RAM port in the same cycle the request is seen, and they never stall the core. Off-chip accesses run a fixed strobe sequence on one of two port groups. The sequence is multiplexed (address and data share pins, framed by an address-latch pulse) or non-multiplexed. The block raises `busy` for the whole sequence and pulses `done` when it ends. It drives a group's pins only while its own transfer is running. At all other times every group sits at idle levels, and pin control returns to the surrounding port logic.

Top module: `xmem_ctl`

## Requirements
- R1: Mode encoding on `cfg_mode`: 0 sends every access on-chip; 3 sends every access off-chip; 1 and 2 send effective addresses below 0x1000 on-chip and those at or above 0x1000 off-chip.
- R2: When `req_paged` is 1, the effective address is `{cfg_page, req_addr[7:0]}`; otherwise it is `req_addr`.
- R3: During an off-chip transfer, the owning group's `pin_addr_hi` carries `cfg_page` (as sampled at acceptance) in mode 1, and bits 15:8 of the effective address in modes 2 and 3.
- R4: An on-chip hit that is accepted while idle drives `ram_en`=1 in that same cycle, together with `ram_we`=`req_write`, `ram_addr`= effective address bits 11:0, and `ram_wdata`=`req_wdata`. `busy` stays 0.
- R5: `cfg_hi_grp`=0 places the transfer on group 0 and 1 places it on group 1. The other group keeps idle levels throughout: ALE 0, both strobes 1, addresses, AD and `pin_ad_oe` all 0.
- R6: In multiplexed mode (`cfg_muxed`=1), the first cycle after acceptance has ALE high with address bits 7:0 on AD. The next cycle has ALE low with the address still on AD. Then RD or WR is low for `cfg_strobe`+1 cycles. `pin_addr_lo` stays 0 throughout.
- R7: In non-multiplexed mode, RD or WR is low for `cfg_strobe`+1 cycles starting in the first cycle after acceptance, with address bits 7:0 on `pin_addr_lo` and ALE held at 0.
- R8: A write drives `req_wdata` on AD with `pin_ad_oe`=1 while WR is low. A read keeps `pin_ad_oe`=0 while RD is low and captures the owning group's `pin_din` on the last strobe cycle. `done` is high for exactly one cycle after the strobe ends. From that cycle, `rdata` shows the captured byte, and `rdata` is unchanged by writes.
- R9: `pin_own` has at most one bit set. A bit is set exactly while a transfer on that group is running, and all groups are idle from the `done` cycle on.
- R10: `busy` is 1 from the cycle after an off-chip request is accepted until the `done` cycle, where it is 0. Requests presented while `busy` is 1 are ignored: `ram_en` stays 0 and the running sequence is not restarted.
- R11: Changes to `cfg_*` inputs while `busy` is 1 do not alter the running transfer's group, bus style, strobe length or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Memory-map mode (R1 encoding) |
| cfg_hi_grp | input | 1 | Port group select: 0 low group, 1 high group |
| cfg_muxed | input | 1 | 1 multiplexed address/data bus, 0 separate |
| cfg_page | input | 8 | Page register for upper address byte |
| cfg_strobe | input | STB_W | Strobe length minus one, in clocks |
| req_valid | input | 1 | Access request from the core |
| req_write | input | 1 | 1 write, 0 read |
| req_paged | input | 1 | 1 for the 8-bit register-indirect form |
| req_addr | input | 16 | Address from the core |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Off-chip transfer running; core stalls |
| done | output | 1 | One-cycle pulse at off-chip completion |
| rdata | output | 8 | Last byte read off-chip |
| ram_en | output | 1 | On-chip RAM access strobe |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | ONCHIP_AW | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| pin_own | output | 2 | Per-group ownership of the pins |
| pin_ale | output | 2 | Per-group address latch enable |
| pin_rd_n | output | 2 | Per-group read strobe, active low |
| pin_wr_n | output | 2 | Per-group write strobe, active low |
| pin_addr_hi | output | 2x8 | Per-group upper address byte |
| pin_addr_lo | output | 2x8 | Per-group lower address byte (non-multiplexed) |
| pin_ad | output | 2x8 | Per-group address/data output |
| pin_ad_oe | output | 2 | Per-group AD output enable |
| pin_din | input | 2x8 | Per-group data input |

## Verification
The on-chip RAM port and the off-chip decision are combinational in the request cycle, so the bench checks them just after it drives a request and before the next rising edge. Off-chip results are counted from the accepting edge. Multiplexed transfers show ALE in the first cycle after it and the hold phase in the second, with the strobe in cycles 3 to N+2 and `done`, with the captured `rdata`, in cycle N+3. Non-multiplexed transfers show the strobe in cycles 1 to N and `done` in cycle N+1. The bench samples every cycle of each transfer one time unit after the falling edge, and it compares all pins of both groups against the phase that its own cycle count predicts.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;
  localparam int LOW_W  = ADDR_W - PAGE_W;
  localparam int DATA_W = 8;
  localparam int N_GRP  = 2;

  typedef enum logic [1:0] {
    MM_ONCHIP     = 2'd0,
    MM_SPLIT_BANK = 2'd1,
    MM_SPLIT_FLAT = 2'd2,
    MM_OFFCHIP    = 2'd3
  } mem_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_HOLD = 2'd2,
    ST_DATA = 2'd3
  } seq_state_e;

  // Effective address: register-indirect form takes its upper byte from the page.
  function automatic logic [ADDR_W-1:0] eff_addr(logic paged, logic [PAGE_W-1:0] page,
                                                 logic [ADDR_W-1:0] a);
    return paged ? {page, a[LOW_W-1:0]} : a;
  endfunction

  // Off-chip decision for a mode and an effective address.
  function automatic logic goes_off(mem_mode_e m, logic [ADDR_W-1:0] a, int unsigned onchip_aw);
    case (m)
      MM_ONCHIP:  return 1'b0;
      MM_OFFCHIP: return 1'b1;
      default:    return (a >> onchip_aw) != '0;
    endcase
  endfunction

  // Upper address byte placed on the off-chip bus.
  function automatic logic [PAGE_W-1:0] off_upper(mem_mode_e m, logic [PAGE_W-1:0] page,
                                                  logic [ADDR_W-1:0] a);
    return (m == MM_SPLIT_BANK) ? page : a[ADDR_W-1:LOW_W];
  endfunction
endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
  import xmem_pkg::*;
#(
  parameter int ONCHIP_AW = 12
) (
  input  mem_mode_e           mode,
  input  logic                paged,
  input  logic [PAGE_W-1:0]   page,
  input  logic [ADDR_W-1:0]   addr,
  output logic                off_hit,
  output logic [ADDR_W-1:0]   eff,
  output logic [ADDR_W-1:0]   bus_addr
);
  always_comb begin
    eff      = eff_addr(paged, page, addr);
    off_hit  = goes_off(mode, eff, ONCHIP_AW);
    bus_addr = {off_upper(mode, page, eff), eff[LOW_W-1:0]};
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int STB_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         s_write,
  input  logic                         s_muxed,
  input  logic                         s_grp,
  input  logic [STB_W-1:0]             s_strb,
  input  logic [ADDR_W-1:0]            s_addr,
  input  logic [DATA_W-1:0]            s_wdata,
  input  logic [N_GRP-1:0][DATA_W-1:0] din,
  output seq_state_e                   state,
  output logic                         busy,
  output logic                         done,
  output logic                         last_beat,
  output logic                         write_q,
  output logic                         muxed_q,
  output logic                         grp_q,
  output logic [ADDR_W-1:0]            addr_q,
  output logic [DATA_W-1:0]            wdata_q,
  output logic [DATA_W-1:0]            rdata
);
  logic [STB_W-1:0] cnt;

  assign busy      = (state != ST_IDLE);
  assign last_beat = (state == ST_DATA) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      write_q <= 1'b0;
      muxed_q <= 1'b0;
      grp_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          write_q <= s_write;
          muxed_q <= s_muxed;
          grp_q   <= s_grp;
          addr_q  <= s_addr;
          wdata_q <= s_wdata;
          cnt     <= s_strb;
          state   <= s_muxed ? ST_ADDR : ST_DATA;
        end
        ST_ADDR: state <= ST_HOLD;
        ST_HOLD: state <= ST_DATA;
        ST_DATA: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (!write_q) rdata <= din[grp_q];
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R6: the address phase is always followed by the hold phase
  p_addr_then_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ADDR |=> state == ST_HOLD);
  // R6/R7: the strobe phase persists until its count runs out
  p_strobe_persists_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !last_beat) |=> state == ST_DATA);
  // R10: a transfer cannot restart from a running state
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_beat) |=> $stable(addr_q) && $stable(grp_q));
  // R8: completion pulse follows the final strobe beat
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done && !busy);
endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
  import xmem_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  seq_state_e                   state,
  input  logic                         busy,
  input  logic                         done,
  input  logic                         write_q,
  input  logic                         muxed_q,
  input  logic                         grp_q,
  input  logic [ADDR_W-1:0]            addr_q,
  input  logic [DATA_W-1:0]            wdata_q,
  output logic [N_GRP-1:0]             pin_own,
  output logic [N_GRP-1:0]             pin_ale,
  output logic [N_GRP-1:0]             pin_rd_n,
  output logic [N_GRP-1:0]             pin_wr_n,
  output logic [N_GRP-1:0][PAGE_W-1:0] pin_addr_hi,
  output logic [N_GRP-1:0][LOW_W-1:0]  pin_addr_lo,
  output logic [N_GRP-1:0][DATA_W-1:0] pin_ad,
  output logic [N_GRP-1:0]             pin_ad_oe
);
  logic addr_ph, data_ph;
  assign addr_ph = (state == ST_ADDR) || (state == ST_HOLD);
  assign data_ph = (state == ST_DATA);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic own;
    assign own            = busy && (grp_q == g[0]);
    assign pin_own[g]     = own;
    assign pin_ale[g]     = own && (state == ST_ADDR);
    assign pin_rd_n[g]    = !(own && data_ph && !write_q);
    assign pin_wr_n[g]    = !(own && data_ph && write_q);
    assign pin_addr_hi[g] = own ? addr_q[ADDR_W-1:LOW_W] : '0;
    assign pin_addr_lo[g] = (own && !muxed_q) ? addr_q[LOW_W-1:0] : '0;
    assign pin_ad_oe[g]   = own && (addr_ph || (data_ph && write_q));
    always_comb begin
      pin_ad[g] = '0;
      if (own && addr_ph)                 pin_ad[g] = addr_q[LOW_W-1:0];
      else if (own && data_ph && write_q) pin_ad[g] = wdata_q;
    end

    // R8: read and write strobes never overlap on a group
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!pin_rd_n[g] && !pin_wr_n[g]));
    // R6: ALE is a single-cycle pulse followed by a strobe-free hold cycle
    p_ale_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_ale[g] |=> !pin_ale[g] && pin_rd_n[g] && pin_wr_n[g] && pin_own[g]);
    // R8: a strobe releases only at completion
    p_rd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_rd_n[g]) |-> done);
    p_wr_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_wr_n[g]) |-> done);
  end

  // R9: at most one owner, and ownership exactly while busy
  p_own_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_own));
  p_own_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_own != '0) == busy);
endmodule

// File: rtl/xmem_ctl.sv
module xmem_ctl
  import xmem_pkg::*;
#(
  parameter int ONCHIP_AW = 12,
  parameter int STB_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   cfg_mode,
  input  logic                         cfg_hi_grp,
  input  logic                         cfg_muxed,
  input  logic [7:0]                   cfg_page,
  input  logic [STB_W-1:0]             cfg_strobe,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic                         req_paged,
  input  logic [15:0]                  req_addr,
  input  logic [7:0]                   req_wdata,
  output logic                         busy,
  output logic                         done,
  output logic [7:0]                   rdata,
  output logic                         ram_en,
  output logic                         ram_we,
  output logic [ONCHIP_AW-1:0]         ram_addr,
  output logic [7:0]                   ram_wdata,
  output logic [1:0]                   pin_own,
  output logic [1:0]                   pin_ale,
  output logic [1:0]                   pin_rd_n,
  output logic [1:0]                   pin_wr_n,
  output logic [1:0][7:0]              pin_addr_hi,
  output logic [1:0][7:0]              pin_addr_lo,
  output logic [1:0][7:0]              pin_ad,
  output logic [1:0]                   pin_ad_oe,
  input  logic [1:0][7:0]              pin_din
);
  logic              off_hit, start, accept;
  logic [ADDR_W-1:0] eff, bus_addr, addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q, muxed_q, grp_q, last_beat;
  seq_state_e        state;

  xmem_decode #(.ONCHIP_AW(ONCHIP_AW)) u_dec (
    .mode(mem_mode_e'(cfg_mode)), .paged(req_paged), .page(cfg_page), .addr(req_addr),
    .off_hit(off_hit), .eff(eff), .bus_addr(bus_addr)
  );

  assign accept    = req_valid && !busy;
  assign start     = accept && off_hit;
  assign ram_en    = accept && !off_hit;
  assign ram_we    = ram_en && req_write;
  assign ram_addr  = eff[ONCHIP_AW-1:0];
  assign ram_wdata = req_wdata;

  xmem_seq #(.STB_W(STB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .s_write(req_write), .s_muxed(cfg_muxed),
    .s_grp(cfg_hi_grp), .s_strb(cfg_strobe), .s_addr(bus_addr), .s_wdata(req_wdata),
    .din(pin_din), .state(state), .busy(busy), .done(done), .last_beat(last_beat),
    .write_q(write_q), .muxed_q(muxed_q), .grp_q(grp_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .rdata(rdata)
  );

  xmem_pins u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .busy(busy), .done(done), .write_q(write_q),
    .muxed_q(muxed_q), .grp_q(grp_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .pin_own(pin_own), .pin_ale(pin_ale), .pin_rd_n(pin_rd_n), .pin_wr_n(pin_wr_n),
    .pin_addr_hi(pin_addr_hi), .pin_addr_lo(pin_addr_lo), .pin_ad(pin_ad),
    .pin_ad_oe(pin_ad_oe)
  );

  // R4/R10: on-chip access only while the off-chip sequencer is idle
  p_ram_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !busy);
  // R10: an accepted off-chip request makes the block busy next cycle
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R8: completion only ends a running transfer
  p_done_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
endmodule

// File: tb/xmem_ctl_tb.sv
module xmem_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic cfg_hi_grp = 1'b0, cfg_muxed = 1'b0;
  logic [7:0] cfg_page = '0;
  logic [1:0] cfg_strobe = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_paged = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, ram_en, ram_we;
  logic [7:0] rdata, ram_wdata;
  logic [11:0] ram_addr;
  logic [1:0] pin_own, pin_ale, pin_rd_n, pin_wr_n, pin_ad_oe;
  logic [1:0][7:0] pin_addr_hi, pin_addr_lo, pin_ad;
  logic [1:0][7:0] pin_din = '0;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_rdata = 8'h00;

  xmem_ctl dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] b_eff(logic pg, logic [7:0] page, logic [15:0] a);
    logic [15:0] r = a;
    if (pg) r[15:8] = page;
    return r;
  endfunction

  function automatic logic b_off(logic [1:0] m, logic [15:0] e);
    if (m == 2'd0) return 1'b0;
    if (m == 2'd3) return 1'b1;
    return e >= 16'h1000;
  endfunction

  function automatic logic [7:0] b_hi(logic [1:0] m, logic [7:0] page, logic [15:0] e);
    if (m == 2'd1) return page;
    return e[15:8];
  endfunction

  task automatic check_idle_grp(int g, string tag);
    chk({tag, " idle ale"}, 32'(pin_ale[g]), 0);
    chk({tag, " idle rd_n/wr_n"}, {30'd0, pin_rd_n[g], pin_wr_n[g]}, 3);
    chk({tag, " idle pins"}, {pin_addr_hi[g], pin_addr_lo[g], pin_ad[g], 7'd0, pin_ad_oe[g]}, 0);
  endtask

  task automatic access(logic [1:0] m, logic pg, logic [7:0] page, logic [15:0] a,
                        logic wr, logic [7:0] wd, logic hi, logic mx, logic [1:0] stb,
                        logic [7:0] dv);
    logic [15:0] e;
    logic off;
    int n, total;
    @(negedge clk);
    cfg_mode = m; req_paged = pg; cfg_page = page; req_addr = a; req_write = wr;
    req_wdata = wd; cfg_hi_grp = hi; cfg_muxed = mx; cfg_strobe = stb;
    pin_din[hi] = dv; pin_din[!hi] = ~dv; req_valid = 1'b1;
    #1;
    e = b_eff(pg, page, a);
    off = b_off(m, e);
    chk("R1 on-chip select", 32'(ram_en), 32'(!off));
    chk("R10 idle busy", 32'(busy), 0);
    if (!off) begin
      chk("R2/R4 ram_addr", 32'(ram_addr), 32'(e[11:0]));
      chk("R4 ram_we/wdata", {23'd0, ram_we, ram_wdata}, {23'd0, wr, wd});
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R4 no stall", {30'd0, busy, done}, 0);
      chk("R9 on-chip leaves pins", 32'(pin_own), 0);
      return;
    end
    n = int'(stb) + 1;
    total = mx ? n + 2 : n;
    for (int t = 0; t < total; t++) begin
      logic aph, hph, dph;
      @(negedge clk);
      req_valid = 1'b0;
      if (t == 0) begin  // R11: scramble configuration mid-transfer
        cfg_hi_grp = ~hi; cfg_muxed = ~mx; cfg_strobe = ~stb; cfg_page = ~page;
        cfg_mode = ~m;
      end
      #1;
      aph = mx && (t == 0);
      hph = mx && (t == 1);
      dph = !aph && !hph;
      chk("R10 busy", 32'(busy), 1);
      chk("R5/R9 own", 32'(pin_own), 32'(2'b01 << hi));
      chk("R6 ale", 32'(pin_ale[hi]), 32'(aph));
      chk("R6/R7 rd_n", 32'(pin_rd_n[hi]), 32'(!(dph && !wr)));
      chk("R6/R7 wr_n", 32'(pin_wr_n[hi]), 32'(!(dph && wr)));
      chk("R3/R11 addr_hi", 32'(pin_addr_hi[hi]), 32'(b_hi(m, page, e)));
      chk("R6/R7 addr_lo", 32'(pin_addr_lo[hi]), mx ? 0 : 32'(e[7:0]));
      if (aph || hph) chk("R6 ad carries address", {23'd0, pin_ad_oe[hi], pin_ad[hi]}, {23'd1, e[7:0]});
      else chk("R8 ad data", {23'd0, pin_ad_oe[hi], pin_ad[hi]}, wr ? {23'd1, wd} : 0);
      check_idle_grp(int'(!hi), "R5");
      if (t == 0) begin  // R10: request while busy is ignored
        req_valid = 1'b1; req_addr = 16'h0010; cfg_mode = 2'd0;
        #1;
        chk("R10 ignored ram_en", 32'(ram_en), 0);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (!wr) exp_rdata = dv;
    chk("R8 done pulse", {30'd0, done, busy}, 2);
    chk("R8 rdata", 32'(rdata), 32'(exp_rdata));
    chk("R9 released", 32'(pin_own), 0);
    check_idle_grp(0, "R9");
    check_idle_grp(1, "R9");
    @(negedge clk);
    #1;
    chk("R8 done one cycle", 32'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    #(CLK_PERIOD * 3);
    #1;
    chk("R10 reset busy/done", {30'd0, busy, done}, 0);
    chk("R9 reset own", 32'(pin_own), 0);
    chk("R8 reset rdata", 32'(rdata), 0);
    check_idle_grp(0, "R9 reset");
    check_idle_grp(1, "R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    access(2'd2, 0, 8'h00, 16'h0FFF, 0, 8'h00, 0, 1, 2'd0, 8'h11);  // R1 split, last on-chip byte
    access(2'd2, 0, 8'h00, 16'h1000, 0, 8'h00, 0, 1, 2'd0, 8'h5A);  // R1 first off-chip byte
    access(2'd0, 0, 8'h00, 16'hFFFF, 1, 8'h77, 1, 0, 2'd3, 8'h00);  // R1 on-chip only
    access(2'd3, 0, 8'h00, 16'h0000, 1, 8'hC3, 1, 0, 2'd3, 8'h00);  // R1 off-chip only
    access(2'd1, 1, 8'h0F, 16'hAAFF, 0, 8'h00, 0, 0, 2'd1, 8'h00);  // R2 page below 4 KB
    access(2'd1, 1, 8'h10, 16'h0034, 0, 8'h00, 1, 1, 2'd2, 8'hE7);  // R2 page at 4 KB
    access(2'd1, 0, 8'hAB, 16'h2345, 1, 8'h9C, 0, 1, 2'd3, 8'h00);  // R3 banked upper byte
    access(2'd2, 0, 8'hAB, 16'h2345, 0, 8'h00, 1, 1, 2'd0, 8'h3D);  // R3 flat upper byte
    for (int i = 0; i < 400; i++) begin
      access(2'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), 1'($urandom),
             8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule